// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Dual Count Enables

This block is a binary up counter, four bits wide by default. All state bits update together on the rising edge of the clock. An active-low clear drives the count to zero at once, without waiting for a clock edge. An active-low load copies a preset word into the counter on the next rising edge. Counting needs two enables, and both must be high. One of them, the chain enable, also gates the terminal-count carry output combinationally.

Wider synchronous counters are built by chaining instances. Each stage's carry drives the next stage's chain enable. The clock, the clear and the parallel enable are shared by all stages. The higher stage then advances on the same edge that wraps the lower stage to zero. All pins are plain control and data levels. The block has no handshake, because a new count is available every cycle and no data stream needs back-pressure.

Top module: `ctr_preset_bin`

## Requirements
- R1: While `clr_n` is 0, `count_q` is all zeros within the same time step, whatever the clock, load or enables are doing. The carry is therefore 0.
- R2: With `clr_n`=1 and `load_n`=0, the rising edge copies `preset_val` into `count_q`. The enables have no effect on that edge.
- R3: `load_n` is sampled only at the rising edge. A low pulse on `load_n` that ends before the edge leaves that edge to count or hold as the enables decide.
- R4: With `clr_n`=1, `load_n`=1, `en_par`=1 and `en_chain`=1, each rising edge adds one to `count_q`.
- R5: With `clr_n`=1, `load_n`=1 and either `en_par` or `en_chain` at 0, `count_q` keeps its value across the edge.
- R6: `carry_o` is 1 exactly when `en_chain`=1 and `count_q` is all ones (15 at the default width). It follows `en_chain` with no clock edge.
- R7: Counting from all ones wraps `count_q` to 0, and `carry_o` falls with the wrap.
- R8: When stages are chained (carry into the next stage's `en_chain`, with clock, clear and `en_par` common), the chain counts as one wider binary counter. This includes the crossing from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| clr_n | input | 1 | Active-low clear, acts immediately |
| load_n | input | 1 | Active-low parallel load, sampled at the rising edge |
| en_par | input | 1 | Count enable that does not touch the carry |
| en_chain | input | 1 | Count enable that also gates the carry |
| preset_val | input | W | Word loaded on a load edge |
| count_q | output | W | Current count |
| carry_o | output | 1 | Terminal-count carry |

## Verification
Load, count and hold results are due at the first rising edge after the inputs are driven. The bench drives inputs at the falling edge and compares against its reference model 2 ns after the rising edge. Clear and carry are due with no edge at all, so the bench checks them 1 ns after it changes `clr_n` or `en_chain`, in the middle of the low phase. A load pulse is opened and closed between two edges to show that only the edge-time level matters. A three-stage chain is preset just below 4095 and compared on every edge as it crosses to zero.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_chain,
  output ctr_op_e op
);
  // load outranks both enables
  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (en_par && en_chain) op = OP_INC;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_sel.sv
module ctr_next_sel
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  ctr_op_e      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] preset,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = preset;
      OP_INC:  nxt = cur + ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end

  // R1: clear holds the state at zero, sampled mid-cycle
  assert_clear_zero_R1: assert property (@(negedge clk)
    !clr_n |-> (q == '0));
endmodule

// File: rtl/ctr_carry_gate.sv
module ctr_carry_gate #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         en_chain,
  output logic         carry
);
  logic [W:0] chain;
  assign chain[0] = en_chain;
  for (genvar i = 0; i < W; i++) begin : g_and
    assign chain[i+1] = chain[i] & cur[i];
  end
  assign carry = chain[W];
endmodule

// File: rtl/ctr_preset_bin.sv
module ctr_preset_bin
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_chain,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] count_q,
  output logic         carry_o
);
  localparam logic [W-1:0] TOP = '1;

  ctr_op_e      op;
  logic [W-1:0] nxt;

  ctr_op_decode u_dec (
    .load_n(load_n), .en_par(en_par), .en_chain(en_chain), .op(op)
  );

  ctr_next_sel #(.W(W)) u_sel (
    .op(op), .cur(count_q), .preset(preset_val), .nxt(nxt)
  );

  ctr_state_reg #(.W(W)) u_reg (
    .clk(clk), .clr_n(clr_n), .d(nxt), .q(count_q)
  );

  ctr_carry_gate #(.W(W)) u_cy (
    .cur(count_q), .en_chain(en_chain), .carry(carry_o)
  );

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (count_q == $past(preset_val)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_chain) |=> (count_q == $past(count_q) + W'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_chain)) |=> $stable(count_q));

  assert_carry_terminal_R6: assert property (@(negedge clk) disable iff (!clr_n)
    carry_o |-> (en_chain && count_q == TOP));

  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_chain && count_q == TOP) |=> (count_q == '0));
endmodule

// File: tb/ctr_chain.sv
module ctr_chain #(
  parameter int STAGES = 3,
  parameter int W      = 4
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  load_n,
  input  logic                  en_par,
  input  logic                  en_first,
  input  logic [STAGES*W-1:0]   preset_val,
  output logic [STAGES*W-1:0]   count_q,
  output logic                  carry_last
);
  logic [STAGES:0] link;
  assign link[0] = en_first;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    ctr_preset_bin #(.W(W)) u_st (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
      .en_chain(link[s]), .preset_val(preset_val[s*W +: W]),
      .count_q(count_q[s*W +: W]), .carry_o(link[s+1])
    );
  end
  assign carry_last = link[STAGES];
endmodule

// File: tb/sim_ctr_preset_bin.sv
module sim_ctr_preset_bin;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_chain = 1'b0;
  logic [3:0] preset_val = '0;
  logic [3:0] count_q;
  logic       carry_o;

  logic        c_clr_n = 1'b0, c_load_n = 1'b1, c_en_par = 1'b0, c_en_first = 1'b0;
  logic [11:0] c_preset = '0;
  logic [11:0] c_count;
  logic        c_carry;

  int n_chk = 0, n_err = 0;
  int model = 0;
  int cmodel = 0;
  bit done = 0;

  ctr_preset_bin #(.W(4)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_chain(en_chain), .preset_val(preset_val),
    .count_q(count_q), .carry_o(carry_o)
  );

  ctr_chain #(.STAGES(3), .W(4)) u_chain (
    .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .en_par(c_en_par),
    .en_first(c_en_first), .preset_val(c_preset),
    .count_q(c_count), .carry_last(c_carry)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit l, input bit p, input bit t, input logic [3:0] v);
    string tag;
    bit wrapped;
    wrapped = 0;
    @(negedge clk);
    clr_n = c; load_n = l; en_par = p; en_chain = t; preset_val = v;
    if (!c) begin
      model = 0;
      #1;
      chk("R1 clear immediate", 32'(count_q), 0);
    end
    @(posedge clk);
    if (!c) tag = "R1 clear held";
    else if (!l) begin model = v; tag = "R2 load"; end
    else if (p && t) begin
      wrapped = (model == 15);
      model = (model + 1) % 16;
      tag = wrapped ? "R7 wrap" : "R4 count";
    end else tag = "R5 hold";
    #2;
    chk(tag, 32'(count_q), 32'(model));
    chk("R6 carry", 32'(carry_o), 32'(t && model == 15));
  endtask

  task automatic cstep(input bit l, input bit t, input logic [11:0] v);
    @(negedge clk);
    c_clr_n = 1'b1; c_load_n = l; c_en_par = 1'b1; c_en_first = t; c_preset = v;
    @(posedge clk);
    if (!l) cmodel = v;
    else if (t) cmodel = (cmodel + 1) % 4096;
    #2;
    chk("R8 chain count", 32'(c_count), 32'(cmodel));
    chk("R8 chain carry", 32'(c_carry), 32'(t && cmodel == 4095));
  endtask

  initial begin
    #1;
    chk("R1 reset count", 32'(count_q), 0);
    chk("R1 reset carry", 32'(carry_o), 0);
    step(0, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    // load wins over enables
    step(1, 0, 1, 1, 4'd9);
    step(1, 0, 0, 0, 4'd13);
    step(1, 1, 0, 1, 4'd0);
    step(1, 1, 1, 0, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    // R6: carry follows en_chain with no edge
    step(1, 0, 0, 1, 4'd15);
    @(negedge clk);
    en_chain = 1'b0;
    #1;
    chk("R6 carry drops without edge", 32'(carry_o), 0);
    en_chain = 1'b1;
    #1;
    chk("R6 carry rises without edge", 32'(carry_o), 1);
    // R3: load pulse closed before the edge
    @(negedge clk);
    load_n = 1'b0; preset_val = 4'd3; en_par = 1'b1; en_chain = 1'b1;
    #1;
    load_n = 1'b1;
    @(posedge clk);
    model = (model + 1) % 16;
    #2;
    chk("R3 load pulse ignored", 32'(count_q), 32'(model));
    // R1: clear in the middle of counting
    step(1, 0, 0, 0, 4'd11);
    step(0, 1, 1, 1, 4'd0);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 16) != 0, ($urandom % 6) != 0,
           ($urandom % 4) != 0, ($urandom % 4) != 0, 4'($urandom));
    end
    // R8: three-stage chain across 4095
    @(negedge clk);
    c_clr_n = 1'b0;
    #1;
    chk("R8 chain clear", 32'(c_count), 0);
    cstep(0, 1, 12'd4090);
    for (int i = 0; i < 8; i++) cstep(1, 1, 12'd0);
    cstep(1, 0, 12'd0);
    cstep(0, 1, 12'd255);
    for (int i = 0; i < 3; i++) cstep(1, 1, 12'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule